// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion Status

This block is the event-reporting section of one DMA channel. The channel raises single-cycle event pulses: overflow of its buffer, a bad register access, a threshold crossing, two kinds of timeout, a bus error, end of transfer and end of the memory side. Each pulse sets a sticky flag. Software clears a flag by writing a one to its bit.

An eight-bit mask decides which flags reach the single level-sensitive interrupt line. Software cannot write the mask directly. It has two write-only alias strobes instead. One clears mask bits, which enables those interrupts. The other sets mask bits, which disables them.

A three-bit counter records finished transfers that software has not yet acknowledged. Software acknowledges a transfer by clearing the done flag. It can also wipe the counter through a write-one-to-clear field in the status word. All register state sits behind plain write strobes that share one data word. Flags, mask and counter are presented as continuous outputs.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset the flags are 0x00, the mask is 0xFF (every source masked), the counter is 0 and `irq_o` is low.
- R2: An `evt_i` pulse on bit n sets flag n, and the flag stays set until it is cleared. Bit assignment: 7 buffer overflow, 6 invalid register access, 5 threshold hit, 4 memory-side timeout, 3 stream-side timeout, 2 bus error, 1 transfer done, 0 memory-side done.
- R3: When `flag_clr_we_i` is high, every flag whose bit in `wdata_i[7:0]` is 1 clears on the next edge. Flags whose data bit is 0 are unchanged.
- R4: If an event pulse and a clearing write hit the same flag in the same cycle, the flag is set after the edge.
- R5: When `mask_en_we_i` is high, mask bits whose `wdata_i[7:0]` bit is 1 become 0. Zero data bits leave the mask unchanged. With neither alias strobe high, the mask holds.
- R6: When `mask_dis_we_i` is high, mask bits whose `wdata_i[7:0]` bit is 1 become 1. If both aliases write the same bit in one cycle, that bit ends up 1.
- R7: `irq_o` is high exactly when some flag is set and its mask bit is 0. It follows the registered flags and mask with no extra cycle.
- R8: An event pulse on bit 1 (transfer done) adds one to the counter, modulo 8 (7 wraps to 0).
- R9: A clearing write with `wdata_i[1]`=1 while the done flag is set, and no done event in the same cycle, subtracts one from the counter modulo 8 (0 wraps to 7). The same write with the flag already clear leaves the counter unchanged. A done event plus a done-clearing write in one cycle gives a net +1.
- R10: When `status_we_i` is high, counter bits whose matching bit in `wdata_i[15:13]` is 1 are 0 after the edge. This overrides any increment or decrement in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Event pulses, one bit per source |
| flag_clr_we_i | input | 1 | Write strobe for the write-one-to-clear flag register |
| mask_en_we_i | input | 1 | Write strobe for the mask-enable alias |
| mask_dis_we_i | input | 1 | Write strobe for the mask-disable alias |
| status_we_i | input | 1 | Write strobe for the status word (counter field at [15:13]) |
| wdata_i | input | 32 | Shared write data |
| flags_o | output | 8 | Current event flags |
| mask_o | output | 8 | Current mask, 1 = masked |
| done_cnt_o | output | 3 | Unacknowledged completion count |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded assertions check on every cycle that flags are sticky, that an event beats a same-cycle clear, that each mask alias moves only the bits it writes and that the mask is otherwise stable, that a lone increment or decrement moves the counter by exactly one modulo 8, and that a fully masked state keeps the interrupt low. Other behaviour depends on how operations combine, and only the bench's scenarios show it: a done-clear write against an already clear flag, the net result of an event and a clear in the same cycle, both mask aliases writing one bit, a counter wipe racing an increment, and the wrap in both directions.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned NUM_SRC  = 8;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned DONE_BIT = 1;
  localparam int unsigned CNT_LSB  = 13;
  localparam int unsigned CNT_MSB  = CNT_LSB + CNT_W - 1;
endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int unsigned N        = 8,
  parameter int unsigned DONE_IDX = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_bits_i,
  output logic [N-1:0] flags_o,
  output logic         done_ack_o
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q[i] <= 1'b0;
      else if (evt_i[i])                   flag_q[i] <= 1'b1;
      else if (clr_we_i && clr_bits_i[i])  flag_q[i] <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(clr_we_i && clr_bits_i[i])) |=> flag_q[i]); // R2
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[i] |=> flag_q[i]); // R4
  end

  assign flags_o    = flag_q;
  assign done_ack_o = flag_q[DONE_IDX] && clr_we_i && clr_bits_i[DONE_IDX] && !evt_i[DONE_IDX];
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we_i,
  input  logic         dis_we_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;
  logic [N-1:0] en_sel, dis_sel;

  assign en_sel  = en_we_i  ? bits_i : '0;
  assign dis_sel = dis_we_i ? bits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= (mask_q & ~en_sel) | dis_sel;
  end

  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_we_i && !dis_we_i) |=> $stable(mask_q)); // R5

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_MASK_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (en_we_i && bits_i[i] && !dis_we_i) |=> !mask_q[i]); // R5
    AST_MASK_DIS: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_we_i && bits_i[i]) |=> mask_q[i]); // R6
  end
endmodule

// File: rtl/dma_irq_donecnt.sv
module dma_irq_donecnt #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         dec_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_arith, clr_sel;

  always_comb begin
    cnt_arith = cnt_q;
    if (inc_i && !dec_i)      cnt_arith = cnt_q + W'(1);
    else if (dec_i && !inc_i) cnt_arith = cnt_q - W'(1);
  end

  assign clr_sel = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_arith & ~clr_sel;
  end

  assign cnt_o = cnt_q;

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i && !(clr_we_i && |clr_bits_i)) |=> (cnt_q == $past(cnt_q) + W'(1))); // R8
  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && !(clr_we_i && |clr_bits_i)) |=> (cnt_q == $past(cnt_q) - W'(1))); // R9
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dma_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic                flag_clr_we_i,
  input  logic                mask_en_we_i,
  input  logic                mask_dis_we_i,
  input  logic                status_we_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [NUM_SRC-1:0]  flags_o,
  output logic [NUM_SRC-1:0]  mask_o,
  output logic [CNT_W-1:0]    done_cnt_o,
  output logic                irq_o
);
  logic done_ack;

  dma_irq_flags #(.N(NUM_SRC), .DONE_IDX(DONE_BIT)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .clr_we_i   (flag_clr_we_i),
    .clr_bits_i (wdata_i[NUM_SRC-1:0]),
    .flags_o    (flags_o),
    .done_ack_o (done_ack)
  );

  dma_irq_mask #(.N(NUM_SRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we_i  (mask_en_we_i),
    .dis_we_i (mask_dis_we_i),
    .bits_i   (wdata_i[NUM_SRC-1:0]),
    .mask_o   (mask_o)
  );

  dma_irq_donecnt #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (evt_i[DONE_BIT]),
    .dec_i      (done_ack),
    .clr_we_i   (status_we_i),
    .clr_bits_i (wdata_i[CNT_MSB:CNT_LSB]),
    .cnt_o      (done_cnt_o)
  );

  assign irq_o = |(flags_o & ~mask_o);

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '1) |-> !irq_o); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o == '0) |-> !irq_o); // R7
endmodule

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [23:0] tag;
    logic [7:0]  evt;
    logic        clr, en, dis, st;
    logic [15:0] wd;
    logic [7:0]  eflags;
    logic [7:0]  emask;
    logic [2:0]  ecnt;
    logic        eirq;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{"R2 ", 8'h80, 1'b0,1'b0,1'b0,1'b0, 16'h0000, 8'h80, 8'hFF, 3'd0, 1'b0},
    '{"R5 ", 8'h00, 1'b0,1'b1,1'b0,1'b0, 16'h0080, 8'h80, 8'h7F, 3'd0, 1'b1},
    '{"R3 ", 8'h00, 1'b1,1'b0,1'b0,1'b0, 16'h0001, 8'h80, 8'h7F, 3'd0, 1'b1},
    '{"R3 ", 8'h00, 1'b1,1'b0,1'b0,1'b0, 16'h0080, 8'h00, 8'h7F, 3'd0, 1'b0},
    '{"R8 ", 8'h02, 1'b0,1'b0,1'b0,1'b0, 16'h0000, 8'h02, 8'h7F, 3'd1, 1'b0},
    '{"R8 ", 8'h02, 1'b0,1'b0,1'b0,1'b0, 16'h0000, 8'h02, 8'h7F, 3'd2, 1'b0},
    '{"R7 ", 8'h00, 1'b0,1'b1,1'b0,1'b0, 16'h0002, 8'h02, 8'h7D, 3'd2, 1'b1},
    '{"R9 ", 8'h00, 1'b1,1'b0,1'b0,1'b0, 16'h0002, 8'h00, 8'h7D, 3'd1, 1'b0},
    '{"R9 ", 8'h00, 1'b1,1'b0,1'b0,1'b0, 16'h0002, 8'h00, 8'h7D, 3'd1, 1'b0},
    '{"R4 ", 8'h02, 1'b1,1'b0,1'b0,1'b0, 16'h0002, 8'h02, 8'h7D, 3'd2, 1'b1},
    '{"R6 ", 8'h00, 1'b0,1'b0,1'b1,1'b0, 16'h0002, 8'h02, 8'h7F, 3'd2, 1'b0},
    '{"R6 ", 8'h00, 1'b0,1'b1,1'b1,1'b0, 16'h0001, 8'h02, 8'h7F, 3'd2, 1'b0},
    '{"R5 ", 8'h00, 1'b0,1'b1,1'b0,1'b0, 16'h00FF, 8'h02, 8'h00, 3'd2, 1'b1},
    '{"R10", 8'h00, 1'b0,1'b0,1'b0,1'b1, 16'h4000, 8'h02, 8'h00, 3'd0, 1'b1},
    '{"R2 ", 8'h3C, 1'b0,1'b0,1'b0,1'b0, 16'h0000, 8'h3E, 8'h00, 3'd0, 1'b1},
    '{"R9 ", 8'h00, 1'b1,1'b0,1'b0,1'b0, 16'h00FF, 8'h00, 8'h00, 3'd7, 1'b0},
    '{"R8 ", 8'h02, 1'b0,1'b0,1'b0,1'b0, 16'h0000, 8'h02, 8'h00, 3'd0, 1'b1},
    '{"R10", 8'h02, 1'b0,1'b0,1'b0,1'b1, 16'hE000, 8'h02, 8'h00, 3'd0, 1'b1},
    '{"R6 ", 8'h00, 1'b0,1'b0,1'b1,1'b0, 16'h00FF, 8'h02, 8'hFF, 3'd0, 1'b0},
    '{"R7 ", 8'h41, 1'b0,1'b0,1'b0,1'b0, 16'h0000, 8'h43, 8'hFF, 3'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        flag_clr_we_i = 1'b0, mask_en_we_i = 1'b0, mask_dis_we_i = 1'b0, status_we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [7:0]  flags_o, mask_o;
  logic [2:0]  done_cnt_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .flag_clr_we_i(flag_clr_we_i), .mask_en_we_i(mask_en_we_i),
    .mask_dis_we_i(mask_dis_we_i), .status_we_i(status_we_i),
    .wdata_i(wdata_i), .flags_o(flags_o), .mask_o(mask_o),
    .done_cnt_o(done_cnt_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] ef, input logic [7:0] em,
                       input logic [2:0] ec, input logic ei);
    n_chk++;
    if (flags_o !== ef || mask_o !== em || done_cnt_o !== ec || irq_o !== ei) begin
      n_bad++;
      $display("FAIL %s: flags=%h mask=%h cnt=%0d irq=%b expected flags=%h mask=%h cnt=%0d irq=%b",
               req, flags_o, mask_o, done_cnt_o, irq_o, ef, em, ec, ei);
    end
  endtask

  task automatic idle_inputs();
    evt_i = '0; flag_clr_we_i = 0; mask_en_we_i = 0; mask_dis_we_i = 0;
    status_we_i = 0; wdata_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 8'hFF, 3'd0, 1'b0);   // R1 reset state
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      evt_i = TBL[k].evt; flag_clr_we_i = TBL[k].clr; mask_en_we_i = TBL[k].en;
      mask_dis_we_i = TBL[k].dis; status_we_i = TBL[k].st; wdata_i = {16'h0, TBL[k].wd};
      @(negedge clk);
      check(string'(TBL[k].tag), TBL[k].eflags, TBL[k].emask, TBL[k].ecnt, TBL[k].eirq);
    end
    idle_inputs();
    // R2 flags hold with no writes
    repeat (3) @(negedge clk);
    check("R2", 8'h43, 8'hFF, 3'd0, 1'b0);
    // R9 decrement from 3 without wiping, then counts back
    evt_i = 8'h02; repeat (3) @(negedge clk); idle_inputs();
    check("R8", 8'h43, 8'hFF, 3'd3, 1'b0);
    flag_clr_we_i = 1; wdata_i = 32'h0000_0002; @(negedge clk); idle_inputs();
    check("R9", 8'h41, 8'hFF, 3'd2, 1'b0);
    // R7 enabling an unset source does not raise irq; enabling a set one does
    mask_en_we_i = 1; wdata_i = 32'h0000_0004; @(negedge clk); idle_inputs();
    check("R7", 8'h41, 8'hFB, 3'd2, 1'b0);
    mask_en_we_i = 1; wdata_i = 32'h0000_0001; @(negedge clk); idle_inputs();
    check("R7", 8'h41, 8'hFA, 3'd2, 1'b1);
    // R1 reset in the middle of a run
    rst_n = 1'b0; @(negedge clk);
    check("R1", 8'h00, 8'hFF, 3'd0, 1'b0);
    rst_n = 1'b1; @(negedge clk);
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule